// File: doc/BRIEF.md
# External Interrupt Request Unit

This block sits between a set of peripheral event lines and a small microcontroller core. It watches seven interrupt lines, numbered 0 to 6, finds the selected edge on each one, and records it in a pending flag. A line's request output is high only while its flag is pending and its enable bit is set. The core services one line at a time and reports which one with a vector acknowledge. That acknowledge clears the flag of the named line.

Lines 0 to 5 come from asynchronous inputs. Each input passes through a two-flop synchronizer and one more flop that holds the previous sample, and an edge is found by comparing the two samples. Lines 0, 1 and 4 detect rising edges. Lines 2 and 3 each have a polarity bit that selects the edge. Line 5 is inverted before a rising-edge detector, so it fires on a falling edge at the pin. Line 6 is shared by three sub-sources. Each sub-source has its own synchronizer, pending flag and enable bit, and its flag is cleared only by software, through a write-zero-to-clear mask. The line-6 source is active low: it is low while any enabled sub-flag is pending. That source is inverted before the rising detector, so line 6 fires when the set of enabled pending sub-flags goes from empty to non-empty.

Every pending flag, for the core lines and for the sub-sources, is one two-state machine. FLG_IDLE moves to FLG_PEND on the DETECT transition, taken when an edge is detected. FLG_PEND moves back to FLG_IDLE on the SERVICE transition, taken when a clear request arrives without an edge. A clear request that arrives in the same cycle as an edge takes the COLLIDE transition: the machine stays in FLG_PEND and the event is kept.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset, every enable bit is 0. Every core flag and every sub-source flag is 0, so `irq_req` and `sub_pend` read 0.
- R2: Lines 0, 1 and 4 detect rising edges. An input level sampled at rising clock edge n is seen by the detector at edge n+2, so a rising input sets the flag at edge n+2. The flag does not set unless an edge is detected.
- R3: `edge_pol[0]` selects the edge for line 2 and `edge_pol[1]` selects it for line 3. The value 0 selects falling-edge detection and 1 selects rising. The latency is the same as in R2.
- R4: Line 5 sets its flag on a falling edge of `irq_raw[5]`. A rising edge there has no effect. The latency is the same as in R2.
- R5: `irq_req[i]` is flag i AND enable i. A write with `wr_sel`=0 loads the enable bits, where `wr_data[i]` is the enable for line i. A flag still sets while its line is disabled.
- R6: `ack_valid` with `ack_line`=i (0 to 6) clears flag i at that edge. The other flags are unchanged. The value 7 matches no line.
- R7: If an edge is detected on a line in the same cycle as the acknowledge for that line, the flag stays set.
- R8: A rising edge on `sub_raw[k]` sets `sub_pend[k]`, with the latency of R2. A write with `wr_sel`=1 loads the sub-source enable bits from `wr_data[2:0]`.
- R9: A write with `wr_sel`=2 clears every sub-flag k for which `wr_data[k]` is 0. Ones written are ignored. A sub-edge in the same cycle as a clear of that flag keeps the flag set.
- R10: Line 6's flag sets one edge after the count of enabled, pending sub-flags goes from zero to non-zero. That change can come from a new sub-flag or from a sub-enable write.
- R11: Acknowledging line 6 clears only the core-level flag. `sub_pend` is unchanged.
- R12: A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_raw | input | 6 | Asynchronous request inputs for lines 0 to 5 |
| sub_raw | input | NUM_SUB (3) | Asynchronous sub-source inputs feeding line 6 |
| edge_pol | input | 2 | Edge select for lines 2 and 3 (0 = falling, 1 = rising) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 line enables, 1 sub enables, 2 sub clear mask, 3 reserved |
| wr_data | input | 7 | Write data |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_line | input | 3 | Number of the line being serviced |
| irq_req | output | 7 | Enabled, pending request for each line |
| sub_pend | output | NUM_SUB (3) | Pending flags of the line-6 sub-sources |

## Verification
The assertions assume that `ack_valid`, `wr_en`, `wr_sel`, `wr_data` and `edge_pol` are synchronous to `clk` and stable around each rising edge. Only `irq_raw` and `sub_raw` may change at any time. The bench drives every input on the falling clock edge. It changes the raw lines only at a low random rate, and it keeps `edge_pol` constant within each phase, so the flag assertions see clean edge and clear timing. Sub-clear writes in the random phase mostly carry all ones, so the sub-flags stay pending long enough to exercise the aggregation into line 6.

// File: rtl/eiru_pkg.sv
package eiru_pkg;

    localparam int NUM_LINES  = 7;
    localparam int LINE_W     = $clog2(NUM_LINES + 1);
    localparam int PROG_FIRST = 2;
    localparam int SUB_LINE   = 6;

    typedef enum logic [1:0] {
        DET_RISE     = 2'd0,
        DET_FALL_INV = 2'd1,
        DET_PROG     = 2'd2
    } det_mode_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

    typedef enum logic [1:0] {
        SEL_LINE_EN = 2'b00,
        SEL_SUB_EN  = 2'b01,
        SEL_SUB_CLR = 2'b10,
        SEL_RSVD    = 2'b11
    } wr_sel_e;

    // Detector kind used by each core line
    function automatic det_mode_e mode_of(input int line);
        case (line)
            2, 3:    return DET_PROG;
            5, 6:    return DET_FALL_INV;
            default: return DET_RISE;
        endcase
    endfunction

endpackage

// File: rtl/eiru_sync.sv
module eiru_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
            prev_q <= '0;
        end else begin
            stage_q[0] <= raw;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign cur  = stage_q[STAGES-1];
    assign prev = prev_q;

endmodule

// File: rtl/eiru_flag.sv
module eiru_flag
    import eiru_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr,
    output logic flag
);

    flag_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: DETECT, SERVICE, COLLIDE (stay pending)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (hit)         state_d = FLG_PEND;
            FLG_PEND: if (clr && !hit) state_d = FLG_IDLE;
            default:                   state_d = FLG_IDLE;
        endcase
    end

    // Output
    always_comb begin
        flag = (state_q == FLG_PEND);
    end

    p_set_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !hit) |=> !flag);
    p_clear_on_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag);
    p_collide_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && hit) |=> flag);
    p_pend_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/eiru_subsrc.sv
module eiru_subsrc #(
    parameter int NUM_SUB = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SUB-1:0] sub_cur,
    input  logic [NUM_SUB-1:0] sub_prev,
    input  logic               en_we,
    input  logic               clr_we,
    input  logic [NUM_SUB-1:0] wr_bits,
    output logic [NUM_SUB-1:0] sub_flag,
    output logic               agg,
    output logic               agg_q
);

    logic [NUM_SUB-1:0] sub_en_q;
    logic [NUM_SUB-1:0] sub_hit;
    logic [NUM_SUB-1:0] sub_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_en_q <= '0;
            agg_q    <= 1'b0;
        end else begin
            if (en_we) sub_en_q <= wr_bits;
            agg_q <= agg;
        end
    end

    for (genvar k = 0; k < NUM_SUB; k++) begin : g_sub
        assign sub_hit[k] = sub_cur[k] & ~sub_prev[k];
        // write-zero-to-clear: a one in the mask leaves the flag alone
        assign sub_clr[k] = clr_we & ~wr_bits[k];
        eiru_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .hit  (sub_hit[k]),
            .clr  (sub_clr[k]),
            .flag (sub_flag[k])
        );
    end

    always_comb begin
        agg = |(sub_flag & sub_en_q);
    end

endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
    import eiru_pkg::*;
#(
    parameter int NUM_SUB     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-2:0] irq_raw,
    input  logic [NUM_SUB-1:0]   sub_raw,
    input  logic [1:0]           edge_pol,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [NUM_LINES-1:0] wr_data,
    input  logic                 ack_valid,
    input  logic [LINE_W-1:0]    ack_line,
    output logic [NUM_LINES-1:0] irq_req,
    output logic [NUM_SUB-1:0]   sub_pend
);

    localparam int EXT_LINES = NUM_LINES - 1;

    wr_sel_e              sel;
    logic [EXT_LINES-1:0] ext_cur, ext_prev;
    logic [NUM_SUB-1:0]   sub_cur, sub_prev;
    logic [NUM_LINES-1:0] line_cur, line_prev;
    logic [NUM_LINES-1:0] line_hit, line_flag, ack_hit;
    logic [NUM_LINES-1:0] line_en_q;
    logic                 agg, agg_q;

    assign sel = wr_sel_e'(wr_sel);

    eiru_sync #(.WIDTH(EXT_LINES), .STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .raw(irq_raw), .cur(ext_cur), .prev(ext_prev)
    );

    eiru_sync #(.WIDTH(NUM_SUB), .STAGES(SYNC_STAGES)) u_sync_sub (
        .clk(clk), .rst_n(rst_n), .raw(sub_raw), .cur(sub_cur), .prev(sub_prev)
    );

    eiru_subsrc #(.NUM_SUB(NUM_SUB)) u_subsrc (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_cur (sub_cur),
        .sub_prev(sub_prev),
        .en_we   (wr_en && sel == SEL_SUB_EN),
        .clr_we  (wr_en && sel == SEL_SUB_CLR),
        .wr_bits (wr_data[NUM_SUB-1:0]),
        .sub_flag(sub_pend),
        .agg     (agg),
        .agg_q   (agg_q)
    );

    // Line 6 source is active low: low while any enabled sub-flag is pending
    assign line_cur  = {~agg,   ext_cur};
    assign line_prev = {~agg_q, ext_prev};

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (mode_of(i) == DET_PROG) begin : g_prog
            assign line_hit[i] = edge_pol[i-PROG_FIRST]
                ? (line_cur[i] & ~line_prev[i])
                : (~line_cur[i] & line_prev[i]);
        end else if (mode_of(i) == DET_FALL_INV) begin : g_inv
            logic inv_cur, inv_prev;
            assign inv_cur     = ~line_cur[i];
            assign inv_prev    = ~line_prev[i];
            assign line_hit[i] = inv_cur & ~inv_prev;
        end else begin : g_rise
            assign line_hit[i] = line_cur[i] & ~line_prev[i];
        end

        assign ack_hit[i] = ack_valid && (ack_line == LINE_W'(i));

        eiru_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .hit  (line_hit[i]),
            .clr  (ack_hit[i]),
            .flag (line_flag[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           line_en_q <= '0;
        else if (wr_en && sel == SEL_LINE_EN) line_en_q <= wr_data;
    end

    always_comb begin
        irq_req = line_flag & line_en_q;
    end

    p_line6_from_agg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (agg && !agg_q && !ack_hit[SUB_LINE]) |=> line_flag[SUB_LINE]);

    p_sub_kept_on_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_line == LINE_W'(SUB_LINE) && !(wr_en && sel == SEL_SUB_CLR))
        |=> ((sub_pend & $past(sub_pend)) == $past(sub_pend)));

endmodule

// File: tb/ext_irq_unit_bench.sv
`timescale 1ns/1ps
module ext_irq_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] irq_raw = '0;
    logic [2:0] sub_raw = '0;
    logic [1:0] edge_pol = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [6:0] wr_data = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_line = '0;
    logic [6:0] irq_req;
    logic [2:0] sub_pend;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model state
    logic [5:0] m_s1 = '0, m_s2 = '0, m_s3 = '0;
    logic [2:0] m_t1 = '0, m_t2 = '0, m_t3 = '0;
    logic [6:0] m_flag = '0, m_en = '0;
    logic [2:0] m_sf = '0, m_se = '0;
    logic       m_aggq = 1'b0;

    always #5 clk = ~clk;

    ext_irq_unit u_ext_irq_unit (
        .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .sub_raw(sub_raw),
        .edge_pol(edge_pol), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ack_valid(ack_valid), .ack_line(ack_line), .irq_req(irq_req), .sub_pend(sub_pend)
    );

    function automatic logic [6:0] line_edges(input logic [5:0] c, input logic [5:0] p,
                                              input logic [1:0] pl, input logic agg,
                                              input logic aggq);
        logic [6:0] e;
        e[0] = c[0] & ~p[0];
        e[1] = c[1] & ~p[1];
        e[2] = pl[0] ? (c[2] & ~p[2]) : (~c[2] & p[2]);
        e[3] = pl[1] ? (c[3] & ~p[3]) : (~c[3] & p[3]);
        e[4] = c[4] & ~p[4];
        e[5] = ~c[5] & p[5];
        e[6] = agg & ~aggq;
        return e;
    endfunction

    task automatic model_update();
        logic       agg;
        logic [6:0] e;
        logic [2:0] se, clr;
        agg = |(m_sf & m_se);
        e   = line_edges(m_s2, m_s3, edge_pol, agg, m_aggq);
        for (int i = 0; i < 7; i++)
            if (e[i]) m_flag[i] = 1'b1;
            else if (ack_valid && ack_line == 3'(i)) m_flag[i] = 1'b0;
        se  = m_t2 & ~m_t3;
        clr = (wr_en && wr_sel == 2'd2) ? ~wr_data[2:0] : 3'b000;
        m_sf = se | (m_sf & ~clr);
        if (wr_en && wr_sel == 2'd0) m_en = wr_data;
        if (wr_en && wr_sel == 2'd1) m_se = wr_data[2:0];
        m_aggq = agg;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_raw;
        m_t3 = m_t2; m_t2 = m_t1; m_t1 = sub_raw;
    endtask

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got req=%b sub=%b expected req=%b sub=%b",
                     tag, act[9:3], act[2:0], exp[9:3], exp[2:0]);
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(tag, {irq_req, sub_pend}, {m_flag & m_en, m_sf});
        wr_en = 1'b0;
        ack_valid = 1'b0;
    endtask

    task automatic steps(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    task automatic wr(input logic [1:0] s, input logic [6:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
    endtask

    task automatic ack(input logic [2:0] l);
        ack_valid = 1'b1; ack_line = l;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got no finish expected finish");
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", {irq_req, sub_pend}, 10'd0);

        wr(2'd0, 7'h7F); step("R5 enable all");

        // R2 rising lines with exact latency
        irq_raw[0] = 1'b1; irq_raw[1] = 1'b1; irq_raw[4] = 1'b1;
        step("R2"); step("R2");
        check("R2 not yet", {7'(irq_req & 7'h13), 3'b0}, 10'd0);
        step("R2");
        check("R2 set", {7'(irq_req & 7'h13), 3'b0}, {7'h13, 3'b0});

        // R3 programmable polarity, falling selected
        edge_pol = 2'b00;
        irq_raw[2] = 1'b1; irq_raw[3] = 1'b1; steps(4, "R3 rise ignored");
        check("R3 rise ignored", {7'(irq_req & 7'h0C), 3'b0}, 10'd0);
        irq_raw[2] = 1'b0; irq_raw[3] = 1'b0; steps(3, "R3 fall");
        check("R3 fall", {7'(irq_req & 7'h0C), 3'b0}, {7'h0C, 3'b0});
        ack(3'd2); step("R6 ack2");
        ack(3'd3); step("R6 ack3");
        edge_pol = 2'b11;
        irq_raw[2] = 1'b1; irq_raw[3] = 1'b1; steps(3, "R3 rise");
        check("R3 rise", {7'(irq_req & 7'h0C), 3'b0}, {7'h0C, 3'b0});
        edge_pol = 2'b00;

        // R4 inverted line 5
        irq_raw[5] = 1'b1; steps(4, "R4 rise ignored");
        check("R4 rise ignored", {7'(irq_req & 7'h20), 3'b0}, 10'd0);
        irq_raw[5] = 1'b0; steps(3, "R4 fall");
        check("R4 fall", {7'(irq_req & 7'h20), 3'b0}, {7'h20, 3'b0});

        // R6 acknowledge
        ack(3'd7); step("R6 line7 ignored");
        ack(3'd0); step("R6 ack0");
        check("R6 ack0", {7'(irq_req & 7'h01), 3'b0}, 10'd0);

        // R7 edge collides with acknowledge
        ack(3'd1); step("R7 clear");
        irq_raw[1] = 1'b0; steps(3, "R7");
        irq_raw[1] = 1'b1; step("R7"); step("R7");
        ack(3'd1); step("R7 collide");
        check("R7 collide", {7'(irq_req & 7'h02), 3'b0}, {7'h02, 3'b0});

        // R5 gating
        wr(2'd0, 7'h6F); step("R5 disable4");
        check("R5 disable4", {7'(irq_req & 7'h10), 3'b0}, 10'd0);
        wr(2'd0, 7'h7F); step("R5 enable4");

        // R8 / R10 sub-sources
        wr(2'd1, 7'h05); step("R8 sub enable");
        sub_raw[0] = 1'b1; steps(3, "R8");
        check("R8 sub set", {7'b0, sub_pend}, 10'b001);
        step("R10 line6");
        check("R10 line6", {7'(irq_req & 7'h40), 3'b0}, {7'h40, 3'b0});

        // R11 ack line 6 keeps sub flags
        ack(3'd6); step("R11");
        check("R11", {7'(irq_req & 7'h40), sub_pend}, 10'b001);

        // R9 write-zero-to-clear
        wr(2'd2, 7'h7F); step("R9 ones ignored");
        sub_raw[1] = 1'b1; steps(4, "R9 R10 disabled sub");
        wr(2'd2, 7'h7E); step("R9 clear0");
        check("R9 clear0", {7'b0, sub_pend}, 10'b010);

        // R10 via enable write
        wr(2'd1, 7'h02); step("R10 enable"); step("R10 enable");

        // R12 reserved select
        wr(2'd3, 7'h00); step("R12");

        // random phase
        void'($urandom(32'd8675309));
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'd0) irq_raw[r[6:4] % 6] = ~irq_raw[r[6:4] % 6];
            if (r[8:7] == 2'd0 && r[11:9] < 3'd3) sub_raw[r[10:9]] = ~sub_raw[r[10:9]];
            if (n % 500 == 0) edge_pol = r[13:12];
            if (r[17:14] == 4'd0)
                wr(r[19:18], (r[19:18] == 2'd2 && r[20]) ? 7'h7F : 7'(r[27:21]));
            if (r[29:28] == 2'd0) ack(3'(r[31:30] + r[2:0]));
            step("R2 R3 R4 R5 R6 R9 R10 random");
        end

        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

endmodule